// File: doc/BRIEF.md
# Serial Command and Fault Status Shifter

This block is the serial slave of an eight-channel switch controller. While chip select is low, an external master clocks a 16-bit command word into the block. The word holds eight detect-current enables and eight output on/off bits. In the same frame the block returns a 16-bit status word that carries the fault flags of the eight channels.

A fast system clock samples the serial pins after a two-stage synchronizer and detects serial clock and chip select edges in its own domain. The received word moves to a holding register only when chip select rises, and only when the frame had exactly sixteen falling serial clock edges. Any other frame is thrown away. The holding register drives the parallel command output that feeds the channel drivers.

The data-out pin is qualified by an enable output, which an external pad uses to tri-state the line while chip select is high.

Top module: `octal_cmd_shifter`

## Requirements
- R1: After reset, `cmd_o` is 16'h0000 (all outputs off, all detect currents off), `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: While chip select is high, `sdo_oe_o` and `sdo_o` are 0, and toggling `sck_i` or `sdi_i` leaves `cmd_o` unchanged.
- R3: In a frame with exactly 16 falling `sck_i` edges, `sdi_i` is sampled on each falling edge, most significant bit first. After chip select rises, `cmd_o[15:8]` holds the detect-current enables of channels 8 down to 1 and `cmd_o[7:0]` holds the output bits of channels 8 down to 1. A 1 means on.
- R4: `cmd_o` does not change while chip select is low. It takes the new word no later than 4 system clocks after `cs_n_i` rises.
- R5: A frame with fewer or more than 16 falling `sck_i` edges is discarded, and `cmd_o` keeps its previous value.
- R6: `sdo_o` takes a new bit after each rising `sck_i` edge of a frame, most significant bit first. The 16 bits sent are eight zeros, then the fault flags `fault_i[7]` down to `fault_i[0]`.
- R7: The fault flags are captured when chip select falls. Later changes on `fault_i` do not alter the status sent in that frame.
- R8: `sdo_oe_o` equals the inverse of `cs_n_i` delayed by two system clocks, so it is high within 3 clocks of chip select going low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, held at 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the data-out pad |
| fault_i | input | 8 | Fault flags, bit 7 is channel 8 |
| cmd_o | output | 16 | Applied command: [15:8] detect currents, [7:0] outputs |

## Verification
The assertions assume that the master holds the serial clock low whenever chip select changes. They also assume that each serial clock level lasts several system clocks, so that no edge is lost in the synchronizer. The stimulus follows both rules: it drives chip select only while the serial clock is low, and it holds every serial clock level for six to eight system clocks. Random frames use random edge counts, including zero, short and long frames. Random command words and fault patterns are used, and the fault input is scrambled in the middle of each frame.

// File: rtl/octal_cmd_pkg.sv
package octal_cmd_pkg;
  localparam int unsigned CH_N    = 8;
  localparam int unsigned FRAME_W = 2 * CH_N;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);

  // status word: leading zeros, then channel flags highest channel first
  function automatic logic [FRAME_W-1:0] status_word(input logic [CH_N-1:0] flags);
    return {{(FRAME_W-CH_N){1'b0}}, flags};
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import octal_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               end_i,
  input  logic               shift_i,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] word_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               accept_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q <= {sr_q[FRAME_W-2:0], sdi_i};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o   = sr_q;
  assign cnt_o    = cnt_q;
  assign accept_o = end_i && (cnt_q == CNT_FULL);
endmodule

// File: rtl/tx_frame.sv
module tx_frame
  import octal_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [CH_N-1:0]  fault_i,
  output logic             sdo_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q;
  logic               sdo_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= status_word(fault_i);
      sdo_q <= 1'b0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sdo_q <= sr_q[FRAME_W-1];
      sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sdo_o = sdo_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/octal_cmd_shifter.sv
module octal_cmd_shifter
  import octal_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  input  logic [CH_N-1:0]    fault_i,
  output logic [FRAME_W-1:0] cmd_o
);
  // pin vector order: {cs, sck, sdi}; cs idles high
  localparam int unsigned PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b100;

  logic [PIN_N-1:0] pin_s, pin_prev_q;
  logic cs_s, sck_s, sdi_s;
  logic cs_fall, cs_rise, sck_fall, sck_rise;
  logic [FRAME_W-1:0] rx_word, hold_q;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic frame_ok, tx_bit;

  pin_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_n_i, sck_i, sdi_i}),
    .q_o   (pin_s)
  );

  assign {cs_s, sck_s, sdi_s} = pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_prev_q <= PIN_IDLE;
    else pin_prev_q <= pin_s;
  end

  assign cs_fall  = pin_prev_q[2] && !cs_s;
  assign cs_rise  = !pin_prev_q[2] && cs_s;
  assign sck_fall = !cs_s && pin_prev_q[1] && !sck_s;
  assign sck_rise = !cs_s && !pin_prev_q[1] && sck_s;

  rx_frame u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cs_fall),
    .end_i   (cs_rise),
    .shift_i (sck_fall),
    .sdi_i   (sdi_s),
    .word_o  (rx_word),
    .cnt_o   (rx_cnt),
    .accept_o(frame_ok)
  );

  tx_frame u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cs_fall),
    .shift_i(sck_rise),
    .fault_i(fault_i),
    .sdo_o  (tx_bit),
    .cnt_o  (tx_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (frame_ok) hold_q <= rx_word;
  end

  assign cmd_o    = hold_q;
  assign sdo_oe_o = !cs_s;
  assign sdo_o    = tx_bit && !cs_s;
endmodule

// File: rtl/octal_cmd_shifter_chk.sv
module octal_cmd_shifter_chk
  import octal_cmd_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_n_i,
  input logic               sdo_o,
  input logic               sdo_oe_o,
  input logic [FRAME_W-1:0] cmd_o,
  input logic               cs_s,
  input logic               cs_rise,
  input logic [CNT_W-1:0]   rx_cnt,
  input logic [CNT_W-1:0]   tx_cnt
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  assert_oe_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (sdo_oe_o == !$past(cs_n_i, 2)));

  assert_cmd_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !$stable(cmd_o)) |-> $past(cs_rise));

  assert_cmd_full_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !$stable(cmd_o)) |-> ($past(rx_cnt) == CNT_W'(FRAME_W)));

  assert_idle_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (!cs_s || $stable(rx_cnt)));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  assert_lead_zeros_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && tx_cnt <= CNT_W'(FRAME_W - CH_N)) |-> !sdo_o);
endmodule

bind octal_cmd_shifter octal_cmd_shifter_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_i  (cs_n_i),
  .sdo_o   (sdo_o),
  .sdo_oe_o(sdo_oe_o),
  .cmd_o   (cmd_o),
  .cs_s    (cs_s),
  .cs_rise (cs_rise),
  .rx_cnt  (rx_cnt),
  .tx_cnt  (tx_cnt)
);

// File: tb/octal_cmd_shifter_bench.sv
module octal_cmd_shifter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [7:0] fault = '0;
  logic [15:0] cmd;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_cmd = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  octal_cmd_shifter u_octal_cmd_shifter (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .cs_n_i  (cs_n),
    .sck_i   (sck),
    .sdi_i   (sdi),
    .sdo_o   (sdo),
    .sdo_oe_o(sdo_oe),
    .fault_i (fault),
    .cmd_o   (cmd)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(input logic [7:0] f);
    return {8'h00, f};
  endfunction

  function automatic logic [15:0] next_cmd(input logic [15:0] old, input logic [15:0] w, input int n);
    return (n == 16) ? w : old;
  endfunction

  task automatic run_frame(input logic [15:0] word, input int nfall, input logic [7:0] flt);
    logic [15:0] dout;
    dout = '0;
    fault = flt;
    wait_clk(3);
    cs_n = 1'b0;
    wait_clk(3);
    check("R8 oe after cs low", 32'(sdo_oe), 32'd1);
    wait_clk(3);
    fault = ~flt; // R7: must not reach this frame's status
    for (int i = 0; i < nfall; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'($urandom);
      wait_clk(2);
      sck = 1'b1;
      wait_clk(6);
      if (i < 16) dout[15-i] = sdo;
      if (i == 8) check("R4 cmd held mid-frame", 32'(cmd), 32'(exp_cmd));
      sck = 1'b0;
      wait_clk(6);
    end
    check("R4 cmd held before cs rise", 32'(cmd), 32'(exp_cmd));
    cs_n = 1'b1;
    exp_cmd = next_cmd(exp_cmd, word, nfall);
    wait_clk(4);
    if (nfall == 16) begin
      check("R3 R4 cmd applied", 32'(cmd), 32'(exp_cmd));
      check("R6 R7 status word", 32'(dout), 32'(exp_status(flt)));
    end else begin
      check("R5 bad frame discarded", 32'(cmd), 32'(exp_cmd));
    end
    check("R2 oe low after frame", 32'(sdo_oe), 32'd0);
    wait_clk(2);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    wait_clk(4);
    check("R1 reset cmd", 32'(cmd), 32'h0);
    check("R1 reset oe", 32'(sdo_oe), 32'd0);
    check("R1 reset sdo", 32'(sdo), 32'd0);
    rst_n = 1'b1;
    wait_clk(4);

    // directed corners
    run_frame(16'hFFFF, 16, 8'hA5);
    run_frame(16'h0F3C, 16, 8'h00);
    run_frame(16'h8001, 16, 8'hFF);
    run_frame(16'h1234, 15, 8'h5A);
    run_frame(16'h4321, 17, 8'h81);
    run_frame(16'hAAAA, 0, 8'h01);
    run_frame(16'h0000, 16, 8'h80);

    // R2: activity with cs high
    exp_cmd = 16'h0000;
    for (int i = 0; i < 20; i++) begin
      sdi = 1'($urandom);
      sck = ~sck;
      wait_clk(4);
      check("R2 idle oe", 32'(sdo_oe), 32'd0);
      check("R2 idle sdo", 32'(sdo), 32'd0);
    end
    sck = 1'b0;
    wait_clk(6);
    check("R2 idle cmd unchanged", 32'(cmd), 32'(exp_cmd));

    // random frames
    for (int k = 0; k < 150; k++) begin
      int n;
      n = ($urandom_range(0, 3) != 0) ? 16 : int'($urandom_range(0, 20));
      run_frame(16'($urandom), n, 8'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule